// File: doc/BRIEF.md
# Condition Flag Unit with Branch Decision

This block keeps the sign state of the last value a 16-bit processor wrote to a register. It holds three one-hot flags: negative, zero and strictly positive. The block watches the shared datapath bus. When the control unit raises the flag-load enable, the block classifies the word on the bus and stores the class at the next clock edge. At any other time the flags keep their value. This means stores, branches and other instructions that the control unit does not mark leave the flags unchanged.

For a conditional branch, the control unit presents the instruction word and raises the branch-evaluate strobe. The block compares the three test bits of the instruction with the stored flags. It drives a taken signal in the same cycle, so the program-counter mux can select either the target computed elsewhere or the next sequential address.

A test mask of all zeros never branches. A mask of all ones always branches, because exactly one flag is always set.

Top module: `nzp_branch_unit`

## Requirements
- R1: After reset the flags read N=0, Z=1, P=0. Reset is synchronous and active high.
- R2: When `flag_load` is high at a rising edge, the flags take the class of `bus_word` read as 16-bit two's complement. Bit 15 set gives N. The value zero gives Z. Any other value gives P.
- R3: When `flag_load` is low at a rising edge, the flags hold their previous value, whatever `bus_word` carries.
- R4: Exactly one of `flag_n`, `flag_z`, `flag_p` is high in every cycle.
- R5: `br_taken` is high only while `br_eval` is high. Otherwise it is low.
- R6: With `br_eval` high, `br_taken` is high when any of the following holds: (`instr[11]` and N), (`instr[10]` and Z), (`instr[9]` and P). This is evaluated combinationally from the stored flags.
- R7: A test mask `instr[11:9]` of 000 never takes the branch. A mask of 111 always takes it.
- R8: The selected next PC `pc_next` equals `br_target` when `br_taken` is high and `pc_seq` otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_word | input | 16 | Value on the shared datapath bus |
| flag_load | input | 1 | Load flags from the bus at the next edge |
| br_eval | input | 1 | A branch instruction is being evaluated |
| instr | input | 16 | Current instruction word; bits 11:9 are the test mask |
| pc_seq | input | 16 | Next sequential PC |
| br_target | input | 16 | Branch target from address generation |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_p | output | 1 | Stored positive flag |
| br_taken | output | 1 | Branch decision |
| pc_next | output | 16 | Selected next PC |

## Verification
The assertions check four behaviours on every cycle:
- the one-hot invariant;
- that flags change only after a load;
- that a loaded value lands in the right class;
- that the decision is gated by the evaluate strobe, with the 000 and 111 masks and the PC selection.

Only the bench's scenarios can show the following:
- that sign classification is right at the boundaries (0x8000, 0xFFFF, 0x0001, 0x7FFF);
- that a long run of non-load cycles with changing bus traffic truly leaves the flags intact;
- that every mask against every flag state gives the expected decision.

// File: rtl/nzp_pkg.sv
package nzp_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned MASK_HI = 11;
  localparam int unsigned MASK_LO = 9;

  typedef struct packed {
    logic n;
    logic z;
    logic p;
  } nzp_t;

  localparam nzp_t NZP_RESET = '{n: 1'b0, z: 1'b1, p: 1'b0};

  function automatic nzp_t classify(input logic [WORD_W-1:0] v);
    nzp_t r;
    r.n = v[WORD_W-1];
    r.z = (v == '0);
    r.p = !v[WORD_W-1] && (v != '0);
    return r;
  endfunction

  function automatic logic mask_hit(input logic [2:0] m, input nzp_t f);
    return (m[2] & f.n) | (m[1] & f.z) | (m[0] & f.p);
  endfunction
endpackage

// File: rtl/nzp_classifier.sv
module nzp_classifier
  import nzp_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic [W-1:0] value,
  output nzp_t         cls
);
  logic is_zero;
  logic is_neg;
  assign is_zero = (value == '0);
  assign is_neg  = value[W-1];
  always_comb begin
    cls.n = is_neg;
    cls.z = is_zero;
    cls.p = !is_neg && !is_zero;
  end
endmodule

// File: rtl/nzp_flag_reg.sv
module nzp_flag_reg
  import nzp_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  nzp_t d,
  output nzp_t q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= NZP_RESET;
    else if (load) q <= d;
  end
endmodule

// File: rtl/nzp_branch_eval.sv
module nzp_branch_eval
  import nzp_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         eval,
  input  logic [2:0]   mask,
  input  nzp_t         flags,
  input  logic [W-1:0] pc_seq,
  input  logic [W-1:0] target,
  output logic         taken,
  output logic [W-1:0] pc_next
);
  logic hit_n, hit_z, hit_p;
  assign hit_n = mask[2] & flags.n;
  assign hit_z = mask[1] & flags.z;
  assign hit_p = mask[0] & flags.p;
  assign taken   = eval & (hit_n | hit_z | hit_p);
  assign pc_next = taken ? target : pc_seq;
endmodule

// File: rtl/nzp_branch_unit.sv
module nzp_branch_unit
  import nzp_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] bus_word,
  input  logic         flag_load,
  input  logic         br_eval,
  input  logic [W-1:0] instr,
  input  logic [W-1:0] pc_seq,
  input  logic [W-1:0] br_target,
  output logic         flag_n,
  output logic         flag_z,
  output logic         flag_p,
  output logic         br_taken,
  output logic [W-1:0] pc_next
);
  localparam int unsigned MW = MASK_HI - MASK_LO + 1;

  nzp_t       bus_class;
  nzp_t       flags_q;
  logic [MW-1:0] test_mask;

  assign test_mask = instr[MASK_HI:MASK_LO];

  nzp_classifier #(.W(W)) u_cls (
    .value(bus_word),
    .cls  (bus_class)
  );

  nzp_flag_reg u_flags (
    .clk (clk),
    .rst (rst),
    .load(flag_load),
    .d   (bus_class),
    .q   (flags_q)
  );

  nzp_branch_eval #(.W(W)) u_eval (
    .eval   (br_eval),
    .mask   (test_mask),
    .flags  (flags_q),
    .pc_seq (pc_seq),
    .target (br_target),
    .taken  (br_taken),
    .pc_next(pc_next)
  );

  assign flag_n = flags_q.n;
  assign flag_z = flags_q.z;
  assign flag_p = flags_q.p;
endmodule

// File: rtl/nzp_branch_unit_chk.sv
module nzp_branch_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] bus_word,
  input logic        flag_load,
  input logic        br_eval,
  input logic [15:0] instr,
  input logic [15:0] pc_seq,
  input logic [15:0] br_target,
  input logic        flag_n,
  input logic        flag_z,
  input logic        flag_p,
  input logic        br_taken,
  input logic [15:0] pc_next
);
  logic seen_edge;
  always_ff @(posedge clk) seen_edge <= 1'b1;

  always_comb begin
    if (seen_edge && !rst)
      AST_ONE_HOT: assert ($countones({flag_n, flag_z, flag_p}) == 1); // R4
  end

  AST_RESET_Z: assert property (@(posedge clk) rst |=> (flag_z && !flag_n && !flag_p)); // R1

  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !flag_load |=> ($stable(flag_n) && $stable(flag_z) && $stable(flag_p))); // R3

  AST_LOAD_NEG: assert property (@(posedge clk) disable iff (rst)
    (flag_load && bus_word[15]) |=> flag_n); // R2

  AST_LOAD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (flag_load && bus_word == 16'h0) |=> flag_z); // R2

  AST_LOAD_POS: assert property (@(posedge clk) disable iff (rst)
    (flag_load && !bus_word[15] && bus_word != 16'h0) |=> flag_p); // R2

  AST_GATED: assert property (@(posedge clk) disable iff (rst)
    !br_eval |-> !br_taken); // R5

  AST_MASK_NONE: assert property (@(posedge clk) disable iff (rst)
    (instr[11:9] == 3'b000) |-> !br_taken); // R7

  AST_MASK_ALL: assert property (@(posedge clk) disable iff (rst)
    (br_eval && instr[11:9] == 3'b111) |-> br_taken); // R7

  AST_PC_SEL: assert property (@(posedge clk) disable iff (rst)
    pc_next == (br_taken ? br_target : pc_seq)); // R8
endmodule

bind nzp_branch_unit nzp_branch_unit_chk u_chk (
  .clk(clk), .rst(rst), .bus_word(bus_word), .flag_load(flag_load),
  .br_eval(br_eval), .instr(instr), .pc_seq(pc_seq), .br_target(br_target),
  .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p),
  .br_taken(br_taken), .pc_next(pc_next)
);

// File: tb/sim_nzp_branch_unit.sv
`timescale 1ns/1ps
module sim_nzp_branch_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] bus_word = '0;
  logic flag_load = 1'b0;
  logic br_eval = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] pc_seq = 16'h3001;
  logic [15:0] br_target = 16'h3100;
  logic flag_n, flag_z, flag_p, br_taken;
  logic [15:0] pc_next;

  int tests = 0;
  int fails = 0;
  // reference flags kept as an integer sign code: -1, 0, +1
  int ref_sign = 0;
  bit ref_valid = 1'b0;

  always #10 clk = ~clk;

  nzp_branch_unit u0 (
    .clk(clk), .rst(rst), .bus_word(bus_word), .flag_load(flag_load),
    .br_eval(br_eval), .instr(instr), .pc_seq(pc_seq), .br_target(br_target),
    .flag_n(flag_n), .flag_z(flag_z), .flag_p(flag_p),
    .br_taken(br_taken), .pc_next(pc_next)
  );

  // reference model: updated at each edge from the inputs seen there
  always @(posedge clk) begin
    if (rst) begin
      ref_sign <= 0;
      ref_valid <= 1'b1;
    end else if (flag_load) begin
      ref_sign <= ($signed(bus_word) < 0) ? -1 : (bus_word == 0 ? 0 : 1);
    end
  end

  function automatic bit ref_take(int s, logic [2:0] m, logic ev);
    if (!ev) return 0;
    if (s < 0) return m[2];
    if (s == 0) return m[1];
    return m[0];
  endfunction

  // per-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (ref_valid && !rst) begin
      bit exp_t;
      logic [2:0] exp_f;
      exp_f = {ref_sign < 0, ref_sign == 0, ref_sign > 0};
      exp_t = ref_take(ref_sign, instr[11:9], br_eval);
      tests++;
      if ({flag_n, flag_z, flag_p} !== exp_f) begin
        fails++;
        $display("FAIL R2/R3/R4 flags: got %b expected %b", {flag_n, flag_z, flag_p}, exp_f);
      end
      tests++;
      if (br_taken !== exp_t) begin
        fails++;
        $display("FAIL R5/R6 taken: got %b expected %b", br_taken, exp_t);
      end
      tests++;
      if (pc_next !== (exp_t ? br_target : pc_seq)) begin
        fails++;
        $display("FAIL R8 pc_next: got %h expected %h", pc_next, exp_t ? br_target : pc_seq);
      end
    end
  end

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic load(logic [15:0] v);
    @(negedge clk);
    bus_word = v; flag_load = 1'b1; br_eval = 1'b0;
    @(negedge clk);
    flag_load = 1'b0;
  endtask

  task automatic test_mask(logic [2:0] m, logic exp, string tag);
    instr = {4'b0000, m, 9'h005};
    br_eval = 1'b1;
    #1;
    check(tag, {15'b0, br_taken}, {15'b0, exp});
    @(negedge clk);
    br_eval = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check("R1 reset flags", {13'b0, flag_n, flag_z, flag_p}, 16'b010);
    // R2 boundary classes
    load(16'h8000); check("R2 0x8000 neg", {13'b0, flag_n, flag_z, flag_p}, 16'b100);
    load(16'h0000); check("R2 zero", {13'b0, flag_n, flag_z, flag_p}, 16'b010);
    load(16'h7FFF); check("R2 0x7FFF pos", {13'b0, flag_n, flag_z, flag_p}, 16'b001);
    load(16'hFFFF); check("R2 0xFFFF neg", {13'b0, flag_n, flag_z, flag_p}, 16'b100);
    load(16'h0001); check("R2 0x0001 pos", {13'b0, flag_n, flag_z, flag_p}, 16'b001);
    // R3 hold over bus traffic without load
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      bus_word = 16'h8000 ^ (i * 16'h1357);
    end
    @(negedge clk);
    check("R3 hold", {13'b0, flag_n, flag_z, flag_p}, 16'b001);
    // R6/R7 all masks vs each flag state
    for (int s = 0; s < 3; s++) begin
      load(s == 0 ? 16'hF000 : (s == 1 ? 16'h0000 : 16'h0042));
      for (int m = 0; m < 8; m++) begin
        logic [2:0] mm;
        mm = m[2:0];
        test_mask(mm, (s == 0) ? mm[2] : ((s == 1) ? mm[1] : mm[0]), "R6 mask sweep");
      end
      test_mask(3'b000, 1'b0, "R7 mask 000");
      test_mask(3'b111, 1'b1, "R7 mask 111");
    end
    // R5 taken gated by eval
    @(negedge clk);
    instr = 16'h0E00; br_eval = 1'b0; #1;
    check("R5 no eval", {15'b0, br_taken}, 16'h0);
    // R8 pc selection
    br_eval = 1'b1; br_target = 16'h2F00; pc_seq = 16'h3009; #1;
    check("R8 taken pc", pc_next, 16'h2F00);
    br_eval = 1'b0; #1;
    check("R8 seq pc", pc_next, 16'h3009);
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule